// File: doc/BRIEF.md
# Serial Framing Timer

This block is a programmable timer that paces a serial shifter. A single compare word, read together with a mode select, turns it into one of three engines: a bit-clock generator that also counts the edges of a word, a two-phase pulse-width generator, or a wide divider that toggles its output each time a 16-bit count runs out. The timer output is the shift clock (or the PWM waveform). A compare pulse marks the end of each word, period or count. Two strobes tell the attached shifters when to drive a start bit or a stop bit.

An enable trigger starts the timer from idle. A disable trigger stops it, and a reload trigger restarts the count in the middle of a run. A stop bit can be requested on each compare, on disable, or on both. When a stop bit is requested on disable, the timer keeps running until the next rising edge of its output, so the stop bit gets a full slot. The compare word is read only when a counter loads. A change written during a run therefore takes effect at the next reload.

Top module: `sft_frame_timer`

## Requirements
- R1: After a synchronous reset, `tmr_out`, `cmp_evt`, `start_strb`, `stop_strb` and `busy` are all low. When `busy` is low, `tmr_out` is low.
- R2: In bit-clock mode (`cfg_mode` = 01), with D = `cfg_cmp[7:0]`, the first rising edge of `tmr_out` comes D+1 clocks after the enabling edge. After that, `tmr_out` toggles every D+1 clocks, giving a period of 2(D+1).
- R3: In bit-clock mode, with H = `cfg_cmp[15:8]`, `cmp_evt` pulses for one cycle (H+1)(D+1) clocks after the enabling edge. H+1 output edges make one word, so a word holds (H+1)/2 bits.
- R4: In PWM mode (`cfg_mode` = 10), `tmr_out` goes high on enable for `cfg_cmp[7:0]`+1 clocks, then low for `cfg_cmp[15:8]`+1 clocks, and repeats. `cmp_evt` pulses as each low period ends.
- R5: In wide mode (`cfg_mode` = 00, and also 11), with C = `cfg_cmp[15:0]`, `tmr_out` toggles every C+1 clocks, with its first rise C+1 clocks after enable. `cmp_evt` pulses at every toggle.
- R6: With `cfg_start_en` high, `start_strb` pulses in the cycle right after the enabling edge and at no other time. In bit-clock mode, the first rising edge of the output then reloads the edge count instead of counting it, so a word lasts one more output edge.
- R7: `cfg_stop_sel[0]` (stop on compare) makes `stop_strb` pulse together with each `cmp_evt`. With `cfg_stop_sel` = 00, `stop_strb` never pulses.
- R8: With `cfg_stop_sel[1]` (stop on disable) set, a disable in a run pulses `stop_strb` in the next cycle. `busy` then stays high until the edge where `tmr_out` would rise, at which point the timer goes idle with `tmr_out` low. With the bit clear, the timer goes idle at the disabling edge.
- R9: With `cfg_stop_sel` = 11, a disable in the same cycle as a compare gives exactly one `stop_strb` pulse.
- R10: A reload trigger during a run restarts the count from the compare word. In PWM mode it starts a fresh high period.
- R11: The compare word is sampled only when a counter loads. A change during a run shows first at the next reload.
- R12: A compare word of zero is legal. It gives a divide-by-2 output in the bit-clock and wide modes, and one-clock high and low periods in PWM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 00/11 wide, 01 bit-clock, 10 PWM |
| cfg_cmp | input | 16 | Compare word |
| cfg_start_en | input | 1 | Insert a start bit on enable |
| cfg_stop_sel | input | 2 | Bit 0 stop on compare, bit 1 stop on disable |
| en_trig | input | 1 | Enable the timer from idle |
| dis_trig | input | 1 | Disable a running timer |
| rld_trig | input | 1 | Restart the count during a run |
| tmr_out | output | 1 | Shift clock or PWM output |
| cmp_evt | output | 1 | One-cycle compare pulse |
| start_strb | output | 1 | Start-bit strobe to the shifters |
| stop_strb | output | 1 | Stop-bit strobe to the shifters |
| busy | output | 1 | Timer is running |

## Verification
Every result is a register, so a trigger sampled at edge E0 first shows at E0+1. The bench numbers the samples by the edges counted since the enabling edge. It takes each sample one nanosecond after a rising edge, and it drives each mid-run trigger just after sample n so that edge n+1 sees it. Expected indices come from the formulas above: D+1 for the first bit-clock rise, (H+1+s)(D+1) for the word compare, H+1 and H+L+2 for the PWM fall and rise, and the next rising-edge slot for the end of a stop-on-disable run. The bench sweeps bit-clock, PWM and wide compare values, zero included, and compares the index of the first matching sample against these values.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE = 2'b00,
        MODE_BAUD = 2'b01,
        MODE_PWM  = 2'b10,
        MODE_ALT  = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_STOP = 2'b10
    } tmr_state_e;

    // commands from framing control to the counter core
    typedef struct packed {
        logic load;
        logic run;
        logic clear;
        logic skip;
    } core_cmd_t;

    // events reported by the counter core for the current cycle
    typedef struct packed {
        logic rise;
        logic cmp;
    } core_evt_t;

    function automatic tmr_mode_e norm_mode(input logic [1:0] m);
        tmr_mode_e r;
        r = tmr_mode_e'(m);
        if (r == MODE_ALT) r = MODE_WIDE;
        return r;
    endfunction

endpackage

// File: rtl/sft_count_core.sv
module sft_count_core
    import sft_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] cmp,
    input  core_cmd_t        cmd,
    output core_evt_t        evt,
    output logic             tmr_out
);
    localparam int HALF_W = CNT_W / 2;
    localparam logic [HALF_W-1:0] LO_ONE = HALF_W'(1);
    localparam logic [CNT_W-1:0]  W_ONE  = CNT_W'(1);

    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic [HALF_W-1:0] cmp_lo, cmp_hi;
    logic              out_q;
    logic              lo_zero, hi_zero, wide_zero;
    logic              tick, cmp_hit;

    assign cmp_lo    = cmp[HALF_W-1:0];
    assign cmp_hi    = cmp[CNT_W-1:HALF_W];
    assign lo_zero   = (cnt_lo == '0);
    assign hi_zero   = (cnt_hi == '0);
    assign wide_zero = lo_zero & hi_zero;
    assign tmr_out   = out_q;

    always_comb begin
        tick    = 1'b0;
        cmp_hit = 1'b0;
        case (mode)
            MODE_BAUD: begin
                tick    = lo_zero;
                cmp_hit = lo_zero & hi_zero & ~(cmd.skip & ~out_q);
            end
            MODE_PWM: begin
                tick    = lo_zero;
                cmp_hit = lo_zero & ~out_q;
            end
            default: begin
                tick    = wide_zero;
                cmp_hit = wide_zero;
            end
        endcase
        evt.rise = cmd.run & tick & ~out_q;
        evt.cmp  = cmd.run & cmp_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            out_q  <= 1'b0;
        end else if (cmd.clear) begin
            out_q <= 1'b0;
        end else if (cmd.load) begin
            cnt_lo <= cmp_lo;
            cnt_hi <= cmp_hi;
            out_q  <= (mode == MODE_PWM);
        end else if (cmd.run) begin
            case (mode)
                MODE_BAUD: begin
                    if (lo_zero) begin
                        cnt_lo <= cmp_lo;
                        out_q  <= ~out_q;
                        if ((cmd.skip && !out_q) || hi_zero)
                            cnt_hi <= cmp_hi;
                        else
                            cnt_hi <= cnt_hi - LO_ONE;
                    end else begin
                        cnt_lo <= cnt_lo - LO_ONE;
                    end
                end
                MODE_PWM: begin
                    if (lo_zero) begin
                        out_q  <= ~out_q;
                        cnt_lo <= out_q ? cmp_hi : cmp_lo;
                    end else begin
                        cnt_lo <= cnt_lo - LO_ONE;
                    end
                end
                default: begin
                    if (wide_zero) begin
                        {cnt_hi, cnt_lo} <= cmp;
                        out_q            <= ~out_q;
                    end else begin
                        {cnt_hi, cnt_lo} <= {cnt_hi, cnt_lo} - W_ONE;
                    end
                end
            endcase
        end
    end

    // R8: a clear always leaves the output low
    p_clear_low_r8: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> !out_q);

    // R4: PWM starts with the high period after a load
    p_pwm_high_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd.load && !cmd.clear && mode == MODE_PWM) |=> out_q);

    // R5: wide mode toggles when the full count is spent
    p_wide_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.run && !cmd.clear && !cmd.load && mode == MODE_WIDE && wide_zero)
        |=> (out_q != $past(out_q)));

    // R2: bit clock holds its level while the divider runs
    p_baud_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd.run && !cmd.clear && !cmd.load && mode == MODE_BAUD && !lo_zero)
        |=> $stable(out_q));

endmodule

// File: rtl/sft_frame_ctrl.sv
module sft_frame_ctrl
    import sft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_trig,
    input  logic       dis_trig,
    input  logic       rld_trig,
    input  logic       start_en,
    input  logic [1:0] stop_sel,
    input  core_evt_t  evt,
    output core_cmd_t  cmd,
    output logic       busy,
    output logic       cmp_evt,
    output logic       start_strb,
    output logic       stop_strb
);
    tmr_state_e state;
    logic       start_pend;
    logic       go_en, dis_now, stop_done, cmp_fire;

    assign go_en     = (state == ST_IDLE) && en_trig;
    assign dis_now   = (state == ST_RUN) && dis_trig;
    assign stop_done = (state == ST_STOP) && evt.rise;

    always_comb begin
        cmd.run   = (state != ST_IDLE);
        cmd.clear = (dis_now && !stop_sel[1]) || stop_done;
        cmd.load  = go_en || ((state == ST_RUN) && rld_trig && !dis_trig);
        cmd.skip  = start_pend;
        cmp_fire  = (state == ST_RUN) && evt.cmp && !cmd.load;
    end

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            start_pend <= 1'b0;
            cmp_evt    <= 1'b0;
            start_strb <= 1'b0;
            stop_strb  <= 1'b0;
        end else begin
            cmp_evt    <= cmp_fire;
            start_strb <= go_en && start_en;
            stop_strb  <= (cmp_fire && stop_sel[0]) || (dis_now && stop_sel[1]);
            case (state)
                ST_IDLE: begin
                    if (en_trig) begin
                        state      <= ST_RUN;
                        start_pend <= start_en;
                    end
                end
                ST_RUN: begin
                    if (dis_trig) begin
                        state <= stop_sel[1] ? ST_STOP : ST_IDLE;
                    end else if (evt.rise && !rld_trig) begin
                        start_pend <= 1'b0;
                    end
                end
                default: begin
                    if (evt.rise) begin
                        state      <= ST_IDLE;
                        start_pend <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R6: start strobe follows an enable with start bit requested
    p_start_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && en_trig && start_en) |=> start_strb);

    // R8: disable with stop-on-disable keeps the timer alive and strobes
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && dis_trig && stop_sel[1]) |=> (state == ST_STOP && stop_strb));

    // R3: compare pulses only come out of a running timer
    p_cmp_running_r3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |=> !cmp_evt);

endmodule

// File: rtl/sft_frame_timer.sv
module sft_frame_timer
    import sft_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_cmp,
    input  logic             cfg_start_en,
    input  logic [1:0]       cfg_stop_sel,
    input  logic             en_trig,
    input  logic             dis_trig,
    input  logic             rld_trig,
    output logic             tmr_out,
    output logic             cmp_evt,
    output logic             start_strb,
    output logic             stop_strb,
    output logic             busy
);
    tmr_mode_e mode_n;
    core_cmd_t cmd;
    core_evt_t evt;

    assign mode_n = norm_mode(cfg_mode);

    sft_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en_trig    (en_trig),
        .dis_trig   (dis_trig),
        .rld_trig   (rld_trig),
        .start_en   (cfg_start_en),
        .stop_sel   (cfg_stop_sel),
        .evt        (evt),
        .cmd        (cmd),
        .busy       (busy),
        .cmp_evt    (cmp_evt),
        .start_strb (start_strb),
        .stop_strb  (stop_strb)
    );

    sft_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_n),
        .cmp     (cfg_cmp),
        .cmd     (cmd),
        .evt     (evt),
        .tmr_out (tmr_out)
    );

    // R1: an idle timer never drives its output high
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tmr_out);

endmodule

// File: tb/sft_frame_timer_bench.sv
module sft_frame_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'b01;
    logic [15:0] cfg_cmp = '0;
    logic        cfg_start_en = 1'b0;
    logic [1:0]  cfg_stop_sel = 2'b00;
    logic        en_trig = 1'b0, dis_trig = 1'b0, rld_trig = 1'b0;
    logic        tmr_out, cmp_evt, start_strb, stop_strb, busy;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] out_v, cmp_v, sta_v, stp_v, bsy_v;

    always #2 clk = ~clk;

    sft_frame_timer u_sft_frame_timer (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_cmp(cfg_cmp),
        .cfg_start_en(cfg_start_en), .cfg_stop_sel(cfg_stop_sel),
        .en_trig(en_trig), .dis_trig(dis_trig), .rld_trig(rld_trig),
        .tmr_out(tmr_out), .cmp_evt(cmp_evt), .start_strb(start_strb),
        .stop_strb(stop_strb), .busy(busy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int first_set(input logic [63:0] v, input int from);
        for (int i = from; i < 64; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int first_clr(input logic [63:0] v, input int from);
        for (int i = from; i < 64; i++) if (!v[i]) return i;
        return -1;
    endfunction

    function automatic int count_set(input logic [63:0] v, input int lo, input int hi);
        int c = 0;
        for (int i = lo; i <= hi; i++) if (v[i]) c++;
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // enable, then sample n = 0 .. nlen-1 one ns after each edge;
    // a trigger tagged k is driven right after sample k-1
    task automatic run_trace(input int nlen, input int dis_at, input int rld_at,
                             input int chg_at, input logic [15:0] chg_val);
        out_v = '0; cmp_v = '0; sta_v = '0; stp_v = '0; bsy_v = '0;
        @(negedge clk);
        en_trig = 1'b1;
        @(posedge clk);
        #1;
        en_trig = 1'b0;
        for (int n = 0; n < nlen; n++) begin
            if (n > 0) begin
                @(posedge clk);
                #1;
            end
            out_v[n] = tmr_out;
            cmp_v[n] = cmp_evt;
            sta_v[n] = start_strb;
            stp_v[n] = stop_strb;
            bsy_v[n] = busy;
            dis_trig = (n + 1 == dis_at);
            rld_trig = (n + 1 == rld_at);
            if (n + 1 == chg_at) cfg_cmp = chg_val;
        end
        dis_trig = 1'b0;
        rld_trig = 1'b0;
        do_reset();
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        check("R1", "tmr_out after reset", int'(tmr_out), 0);
        check("R1", "cmp_evt after reset", int'(cmp_evt), 0);
        check("R1", "start_strb after reset", int'(start_strb), 0);
        check("R1", "stop_strb after reset", int'(stop_strb), 0);
        check("R1", "busy after reset", int'(busy), 0);

        // R2 R3 R6 R12 bit-clock sweep
        cfg_mode = 2'b01;
        cfg_stop_sel = 2'b00;
        for (int d = 0; d < 4; d++) begin
            for (int hc = 0; hc < 3; hc++) begin
                for (int s = 0; s < 2; s++) begin
                    int h, word;
                    h = 2 * hc + 1;
                    word = (h + 1 + s) * (d + 1);
                    cfg_cmp = {8'(h), 8'(d)};
                    cfg_start_en = s[0];
                    run_trace(word + 2, -1, -1, -1, '0);
                    check("R2", "first rise", first_set(out_v, 0), d + 1);
                    check("R2", "first fall", first_clr(out_v, d + 1), 2 * (d + 1));
                    check("R3", "word compare", first_set(cmp_v, 0), word);
                    check("R6", "start strobe at enable", int'(sta_v[0]), s);
                    check("R6", "start strobe count", count_set(sta_v, 0, word + 1), s);
                    check("R1", "busy during run", int'(bsy_v[word]), 1);
                end
            end
        end
        cfg_start_en = 1'b0;

        // R4 R12 PWM sweep
        cfg_mode = 2'b10;
        for (int hp = 0; hp < 4; hp++) begin
            for (int lp = 0; lp < 4; lp++) begin
                cfg_cmp = {8'(lp), 8'(hp)};
                run_trace(hp + lp + 5, -1, -1, -1, '0);
                check("R4", "high at enable", int'(out_v[0]), 1);
                check("R4", "first fall", first_clr(out_v, 0), hp + 1);
                check("R4", "next rise", first_set(out_v, hp + 1), hp + lp + 2);
                check("R4", "period compare", first_set(cmp_v, 0), hp + lp + 2);
            end
        end

        // R5 R12 wide mode, both encodings
        for (int k = 0; k < 6; k++) begin
            int c;
            c = (k == 5) ? 3 : ((k == 4) ? 9 : ((k == 3) ? 5 : k));
            cfg_mode = (k == 5) ? 2'b11 : 2'b00;
            cfg_cmp = 16'(c);
            run_trace(2 * (c + 1) + 2, -1, -1, -1, '0);
            check("R5", "first rise", first_set(out_v, 0), c + 1);
            check("R5", "first fall", first_clr(out_v, c + 1), 2 * (c + 1));
            check("R5", "first compare", first_set(cmp_v, 0), c + 1);
            check("R5", "second compare", first_set(cmp_v, c + 2), 2 * (c + 1));
        end

        // R7 stop on compare versus no stop
        cfg_mode = 2'b01;
        cfg_cmp = {8'd1, 8'd0};
        cfg_stop_sel = 2'b01;
        run_trace(8, -1, -1, -1, '0);
        check("R7", "stop equals compare", int'(stp_v[7:0] == cmp_v[7:0]), 1);
        check("R7", "stop at compare", int'(stp_v[2]), 1);
        cfg_stop_sel = 2'b00;
        run_trace(8, -1, -1, -1, '0);
        check("R7", "no stop pulses with sel 00", count_set(stp_v, 0, 7), 0);

        // R8 stop on disable waits for the next rising slot
        cfg_cmp = {8'd15, 8'd1};
        cfg_stop_sel = 2'b10;
        run_trace(8, 3, -1, -1, '0);
        check("R8", "stop strobe after disable", int'(stp_v[3]), 1);
        check("R8", "single stop strobe", count_set(stp_v, 0, 7), 1);
        check("R8", "busy held", int'(bsy_v[5]), 1);
        check("R8", "idle at rise slot", int'(bsy_v[6]), 0);
        check("R8", "output low at end", int'(out_v[6]), 0);
        cfg_stop_sel = 2'b00;
        run_trace(6, 3, -1, -1, '0);
        check("R8", "immediate idle", int'(bsy_v[3]), 0);
        check("R8", "immediate output low", int'(out_v[3]), 0);
        check("R8", "no stop strobe", int'(stp_v[3]), 0);

        // R9 disable coinciding with compare
        cfg_cmp = {8'd1, 8'd0};
        cfg_stop_sel = 2'b11;
        run_trace(8, 2, -1, -1, '0);
        check("R9", "compare at disable", int'(cmp_v[2]), 1);
        check("R9", "one stop strobe", count_set(stp_v, 0, 7), 1);
        check("R9", "idle after rise slot", int'(bsy_v[3]), 0);
        cfg_stop_sel = 2'b00;

        // R10 reload restarts PWM high
        cfg_mode = 2'b10;
        cfg_cmp = {8'd2, 8'd2};
        run_trace(9, -1, 4, -1, '0);
        check("R10", "low before reload", int'(out_v[3]), 0);
        check("R10", "high after reload", int'(out_v[4]), 1);
        check("R10", "high period kept", int'(out_v[6]), 1);
        check("R10", "fall after high", int'(out_v[7]), 0);

        // R11 compare change waits for the next reload
        cfg_mode = 2'b01;
        cfg_cmp = {8'd15, 8'd3};
        run_trace(7, -1, -1, 1, {8'd15, 8'd0});
        check("R11", "old divider still low", int'(out_v[3]), 0);
        check("R11", "old divider rise", int'(out_v[4]), 1);
        check("R11", "new divider fall", int'(out_v[5]), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule